// File: doc/BRIEF.md
# GPIO Interrupt Line Router

This block takes the per-pin interrupt requests of three GPIO banks of 14, 24 and 32 pins and places them on 41 lines that feed a platform interrupt controller. The lower 32 lines are shared. One bit of a 32-bit routing word belongs to each shared line and chooses which bank drives it. For a clear bit, lines 0–13 carry bank-0 pins and lines 14–31 carry bank-1 pins 0–17. For a set bit, the line carries the bank-2 pin with the same number. Lines 32–37 are not shared and always carry bank-1 pins 18–23.

A pin that does not hold its direct line is not lost. Each bank has a catch-all line (38 for bank 0, 39 for bank 1, 40 for bank 2) that is the OR of every pending interrupt in that bank which currently has no direct line. The routing word resets to zero. After reset, bank 0 and bank 1 own every shared line and all bank-2 interrupts reach the controller only through line 40.

The routing word is written as a full 32-bit word at one address and can be read back at the same address. All 41 outputs come from flip-flops, so the lines change only on a clock edge.

Top module: `gpio_irq_router`

## Requirements
- R1: After reset, all 41 line outputs are 0 and the routing word reads back as 0.
- R2: Line i, for i from 0 to 13, carries bank-0 pin i when routing bit i is 0 and bank-2 pin i when routing bit i is 1.
- R3: Line 14+j, for j from 0 to 17, carries bank-1 pin j when routing bit 14+j is 0 and bank-2 pin 14+j when that bit is 1.
- R4: Lines 32–37 always carry bank-1 pins 18–23, whatever the routing word holds.
- R5: Line 38 is the OR of the bank-0 pins i whose routing bit i is 1.
- R6: Line 39 is the OR of the bank-1 pins j (j from 0 to 17) whose routing bit 14+j is 1. Bank-1 pins 18–23 never contribute to it.
- R7: Line 40 is the OR of the bank-2 pins k whose routing bit k is 0. After reset, every bank-2 pin therefore reaches line 40.
- R8: The line outputs are registered. A change on an input pin appears on the lines one clock edge after the edge that samples it.
- R9: A write with `wr_en` high and `addr` equal to `CTRL_ADDR` loads all 32 bits of `wdata` into the routing word. A write to any other address leaves the word unchanged. `rdata` shows the routing word while `addr` equals `CTRL_ADDR` and shows 0 otherwise.
- R10: A new routing word steers the lines starting one edge after the edge that writes it. The lines produced on the write edge itself still follow the old word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_b0 | input | 14 | Bank-0 pin interrupts |
| irq_b1 | input | 24 | Bank-1 pin interrupts |
| irq_b2 | input | 32 | Bank-2 pin interrupts |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register address |
| wdata | input | 32 | Write data (full word) |
| rdata | output | 32 | Routing word read-back, 0 at other addresses |
| irq_lines | output | 41 | Interrupt lines to the controller |

## Verification
The main hazard is a routing-word write that lands in the same cycle as pin activity. On that edge, the direct lines and the catch-all lines must both still follow the old word, and both must switch together on the next edge.

The bench provokes this by raising a bank-2 pin and writing the routing bit that hands that pin its direct line on the same edge. On the first edge it expects the pin on line 40 and not on its direct line. On the following edge it expects the pin on its direct line and no longer on line 40.

Table vectors then combine mixed routing words with pins set on both sides of a shared line. This checks that a pin is never lost and never reported twice.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
    parameter int B0_PINS = 14;
    parameter int B1_PINS = 24;
    parameter int B2_PINS = 32;
    parameter int ADDR_W  = 4;

    // bank-1 pins that share a line with bank 2, and those that never do
    localparam int B1_SHARED = B2_PINS - B0_PINS;
    localparam int B1_ONLY   = B1_PINS - B1_SHARED;
    localparam int AGG_BASE  = B0_PINS + B1_PINS;
    localparam int N_LINES   = AGG_BASE + 3;

    typedef struct packed {
        logic [B2_PINS-1:0] sel;
        logic [N_LINES-1:0] lines;
    } route_state_t;
endpackage

// File: rtl/gpio_irq_lane_mux.sv
module gpio_irq_lane_mux #(
    parameter int LANES = 14
) (
    input  logic [LANES-1:0] sel,
    input  logic [LANES-1:0] pri_irq,
    input  logic [LANES-1:0] alt_irq,
    output logic [LANES-1:0] line,
    output logic [LANES-1:0] pri_orphan,
    output logic [LANES-1:0] alt_orphan
);
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        always_comb begin
            line[i]       = sel[i] ? alt_irq[i] : pri_irq[i];
            pri_orphan[i] = sel[i] & pri_irq[i];
            alt_orphan[i] = ~sel[i] & alt_irq[i];
        end
    end
endmodule

// File: rtl/gpio_irq_bank_or.sv
module gpio_irq_bank_or #(
    parameter int W = 14
) (
    input  logic [W-1:0] orphans,
    output logic         any
);
    always_comb any = |orphans;
endmodule

// File: rtl/gpio_irq_router.sv
module gpio_irq_router
    import gpio_irq_pkg::*;
#(
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 4'h8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [B0_PINS-1:0]  irq_b0,
    input  logic [B1_PINS-1:0]  irq_b1,
    input  logic [B2_PINS-1:0]  irq_b2,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [B2_PINS-1:0]  wdata,
    output logic [B2_PINS-1:0]  rdata,
    output logic [N_LINES-1:0]  irq_lines
);
    route_state_t state_d, state_q;

    logic [B0_PINS-1:0]   lo_line, lo_pri_orph, lo_alt_orph;
    logic [B1_SHARED-1:0] mid_line, mid_pri_orph, mid_alt_orph;
    logic                 agg0, agg1, agg2;
    logic                 hit;

    gpio_irq_lane_mux #(.LANES(B0_PINS)) u_lo_mux (
        .sel        (state_q.sel[B0_PINS-1:0]),
        .pri_irq    (irq_b0),
        .alt_irq    (irq_b2[B0_PINS-1:0]),
        .line       (lo_line),
        .pri_orphan (lo_pri_orph),
        .alt_orphan (lo_alt_orph)
    );

    gpio_irq_lane_mux #(.LANES(B1_SHARED)) u_mid_mux (
        .sel        (state_q.sel[B2_PINS-1:B0_PINS]),
        .pri_irq    (irq_b1[B1_SHARED-1:0]),
        .alt_irq    (irq_b2[B2_PINS-1:B0_PINS]),
        .line       (mid_line),
        .pri_orphan (mid_pri_orph),
        .alt_orphan (mid_alt_orph)
    );

    gpio_irq_bank_or #(.W(B0_PINS)) u_or0 (
        .orphans (lo_pri_orph),
        .any     (agg0)
    );

    gpio_irq_bank_or #(.W(B1_SHARED)) u_or1 (
        .orphans (mid_pri_orph),
        .any     (agg1)
    );

    gpio_irq_bank_or #(.W(B2_PINS)) u_or2 (
        .orphans ({mid_alt_orph, lo_alt_orph}),
        .any     (agg2)
    );

    assign hit = (addr == CTRL_ADDR);

    always_comb begin
        state_d = state_q;
        if (wr_en && hit) begin
            state_d.sel = wdata;
        end
        state_d.lines = {agg2, agg1, agg0,
                         irq_b1[B1_PINS-1:B1_SHARED],
                         mid_line, lo_line};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign rdata     = hit ? state_q.sel : '0;
    assign irq_lines = state_q.lines;
endmodule

// File: rtl/gpio_irq_router_chk.sv
module gpio_irq_router_chk
    import gpio_irq_pkg::*;
#(
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 4'h8
) (
    input logic               clk,
    input logic               rst_n,
    input logic [B0_PINS-1:0] irq_b0,
    input logic [B1_PINS-1:0] irq_b1,
    input logic [B2_PINS-1:0] irq_b2,
    input logic               wr_en,
    input logic [ADDR_W-1:0]  addr,
    input logic [B2_PINS-1:0] wdata,
    input logic [B2_PINS-1:0] sel,
    input logic [N_LINES-1:0] irq_lines
);
    // R2
    low_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> irq_lines[B0_PINS-1:0] ==
            $past((irq_b0 & ~sel[B0_PINS-1:0]) | (irq_b2[B0_PINS-1:0] & sel[B0_PINS-1:0])));

    // R4
    fixed_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> irq_lines[AGG_BASE-1:B2_PINS] == $past(irq_b1[B1_PINS-1:B1_SHARED]));

    // R6
    agg1_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> irq_lines[AGG_BASE+1] ==
            $past(|(irq_b1[B1_SHARED-1:0] & sel[B2_PINS-1:B0_PINS])));

    // R7
    agg2_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> irq_lines[AGG_BASE+2] == $past(|(irq_b2 & ~sel)));

    // R9
    ctrl_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == CTRL_ADDR) |=> sel == $past(wdata));

    // R9
    ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && addr == CTRL_ADDR) |=> $stable(sel));
endmodule

bind gpio_irq_router gpio_irq_router_chk #(.CTRL_ADDR(CTRL_ADDR)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_b0    (irq_b0),
    .irq_b1    (irq_b1),
    .irq_b2    (irq_b2),
    .wr_en     (wr_en),
    .addr      (addr),
    .wdata     (wdata),
    .sel       (state_q.sel),
    .irq_lines (irq_lines)
);

// File: tb/test_gpio_irq_router.sv
module test_gpio_irq_router;
    localparam logic [3:0] CTRL = 4'h8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [13:0] irq_b0 = '0;
    logic [23:0] irq_b1 = '0;
    logic [31:0] irq_b2 = '0;
    logic        wr_en = 1'b0;
    logic [3:0]  addr = CTRL;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [40:0] irq_lines;

    int errors = 0;
    int checks = 0;

    always #4 clk = ~clk;

    gpio_irq_router #(.CTRL_ADDR(CTRL)) i_gpio_irq_router (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq_b0    (irq_b0),
        .irq_b1    (irq_b1),
        .irq_b2    (irq_b2),
        .wr_en     (wr_en),
        .addr      (addr),
        .wdata     (wdata),
        .rdata     (rdata),
        .irq_lines (irq_lines)
    );

    typedef struct packed {
        logic [31:0] sel;
        logic [13:0] b0;
        logic [23:0] b1;
        logic [31:0] b2;
        logic [13:0] e_lo;
        logic [17:0] e_mid;
        logic [5:0]  e_hi;
        logic [2:0]  e_agg;
    } vec_t;

    localparam vec_t VECS [7] = '{
        '{32'h0000_0000, 14'h1555, 24'hABCDEF, 32'h0000_0000, 14'h1555, 18'h3CDEF, 6'h2A, 3'b000},
        '{32'h0000_0000, 14'h0000, 24'h000000, 32'h0001_0000, 14'h0000, 18'h00000, 6'h00, 3'b100},
        '{32'hFFFF_FFFF, 14'h3FFF, 24'hFFFFFF, 32'h8000_0001, 14'h0001, 18'h20000, 6'h3F, 3'b011},
        '{32'h0000_3FFF, 14'h0004, 24'h000001, 32'h0000_4003, 14'h0003, 18'h00001, 6'h00, 3'b101},
        '{32'hFFFF_C000, 14'h0000, 24'hFC0000, 32'h0000_0000, 14'h0000, 18'h00000, 6'h3F, 3'b000},
        '{32'h0000_0001, 14'h0001, 24'h000000, 32'hFFFF_FFFE, 14'h0000, 18'h00000, 6'h00, 3'b101},
        '{32'h8000_0000, 14'h2000, 24'h020000, 32'h8000_0000, 14'h2000, 18'h20000, 6'h00, 3'b010}
    };

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #(8 * 100000);
        errors++;
        checks++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 lines after reset", 64'(irq_lines), 64'h0);
        check("R1 routing word after reset", 64'(rdata), 64'h0);

        // R7 default: bank-2 pin only on its catch-all line
        irq_b2 = 32'h0000_0020;
        @(negedge clk);
        check("R7 default line 40", 64'(irq_lines[40]), 64'h1);
        check("R7 default line 5 stays bank 0", 64'(irq_lines[5]), 64'h0);

        // R8 one-edge latency on pin change
        irq_b2 = '0;
        irq_b0 = 14'h0008;
        @(negedge clk);
        check("R8 line 3 after edge", 64'(irq_lines[3]), 64'h1);
        irq_b0 = '0;
        check("R8 line 3 before next edge", 64'(irq_lines[3]), 64'h1);
        @(negedge clk);
        check("R8 line 3 cleared", 64'(irq_lines[3]), 64'h0);

        // R10 routing write and pin change on the same edge
        irq_b2 = 32'h0000_0001;
        wr_en  = 1'b1;
        addr   = CTRL;
        wdata  = 32'h0000_0001;
        @(negedge clk);
        wr_en = 1'b0;
        check("R10 write edge line 0 old route", 64'(irq_lines[0]), 64'h0);
        check("R10 write edge line 40 old route", 64'(irq_lines[40]), 64'h1);
        @(negedge clk);
        check("R10 next edge line 0 new route", 64'(irq_lines[0]), 64'h1);
        check("R10 next edge line 40 new route", 64'(irq_lines[40]), 64'h0);

        // table walk: R2 R3 R4 R5 R6 R7
        for (int v = 0; v < 7; v++) begin
            @(negedge clk);
            wr_en  = 1'b1;
            addr   = CTRL;
            wdata  = VECS[v].sel;
            irq_b0 = VECS[v].b0;
            irq_b1 = VECS[v].b1;
            irq_b2 = VECS[v].b2;
            @(negedge clk);
            wr_en = 1'b0;
            @(negedge clk);
            check($sformatf("R2 vec%0d lines 0-13", v), 64'(irq_lines[13:0]), 64'(VECS[v].e_lo));
            check($sformatf("R3 vec%0d lines 14-31", v), 64'(irq_lines[31:14]), 64'(VECS[v].e_mid));
            check($sformatf("R4 vec%0d lines 32-37", v), 64'(irq_lines[37:32]), 64'(VECS[v].e_hi));
            check($sformatf("R5 R6 R7 vec%0d lines 38-40", v), 64'(irq_lines[40:38]), 64'(VECS[v].e_agg));
            check($sformatf("R9 vec%0d readback", v), 64'(rdata), 64'(VECS[v].sel));
        end

        // R9 write to another address is ignored
        @(negedge clk);
        wr_en = 1'b1;
        addr  = 4'h1;
        wdata = 32'h0000_0000;
        #1;
        check("R9 rdata at other address", 64'(rdata), 64'h0);
        @(negedge clk);
        wr_en = 1'b0;
        addr  = CTRL;
        #1;
        check("R9 word kept after foreign write", 64'(rdata), 64'h8000_0000);
        @(negedge clk);
        check("R3 line 31 still bank 2", 64'(irq_lines[31]), 64'h1);

        finish_run();
    end
endmodule